// File: doc/BRIEF.md
# SMBus Block Register Access Bridge

This block sits on the device side of a two-wire management link. It turns block write and block read transactions into reads and writes of a local byte-wide register array. Addresses are 17 bits wide. The bit-level bus layer lives elsewhere. Bytes arrive here on a receive stream (`rx_valid`, `rx_data`, `rx_last`, back-pressured by `rx_ready`), and response bytes leave on a transmit stream (`tx_valid`, `tx_data`, `tx_ready`). Every frame starts with a command byte and ends with the byte marked `rx_last`.

A write is a single frame. It carries a byte count, a configuration byte, two address bytes and one to four data bytes. A read takes two steps:

- An arming frame latches the base address and the burst length.
- A one-byte fetch frame makes the bridge return a count byte, followed by that many data bytes.

The configuration byte has these fields:

- Bit 6: direction.
- Bits 4:1: burst length minus one.
- Bit 0: address bit 16.

The bridge holds a write frame until its last byte has arrived and checks it before anything is stored. A malformed frame therefore raises a one-cycle error pulse and never touches the array.

The array holds 2^`IDX_W` bytes. A byte at 17-bit address A lives at array entry A mod 2^`IDX_W`. Consecutive bytes of a burst go to consecutive addresses, and those addresses wrap modulo 2^17.

Top module: `smb_reg_bridge`

## Requirements
- R1: After reset `rx_ready` is 1, `tx_valid`, `err_pulse` and `pec_flag` are 0, and every array byte reads back as 0.
- R2: A frame with command 0x0F is laid out as: count, config, address[15:8], address[7:0], then N data bytes. Config bit 6 must be 1, config bits 4:1 hold N-1, and config bit 0 is address bit 16. If count = 3+N and N ≤ 4, data byte k is stored at address base+k (mod 2^17), in array entry address mod 2^IDX_W.
- R3: An arming frame uses command 0x0A with count 3. Its config byte has bit 6 = 0 and bits 4:1 = N-1, and is followed by the two address bytes. A later single-byte fetch frame with command 0x09 then gets back a count byte equal to N, followed by the N bytes at base, base+1, and so on.
- R4: A fetch frame with no armed read raises `err_pulse` and returns a single count byte of 0. A fetch consumes the armed read, so a second fetch also returns count 0.
- R5: A write frame is rejected if any of these holds: the count differs from 3+N, the number of bytes after the count differs from the count, config bit 6 is 0, or N > 4. A rejected write pulses `err_pulse` and leaves the array unchanged.
- R6: An arming frame is rejected if its count is not 3, its length is wrong, or config bit 6 is 1. It pulses `err_pulse`, and any earlier armed read is dropped.
- R7: An unknown command, or a fetch frame longer than one byte, pulses `err_pulse` and changes neither the array nor an armed read.
- R8: Command bit 7 (checksum enable) is masked before decoding. When it is set, a write or arming frame carries one extra trailing byte, which is ignored. `pec_flag` shows bit 7 of the last command byte received.
- R9: `err_pulse` lasts exactly one cycle, in the cycle after a frame's last byte is accepted. `rx_ready` is 0 in that cycle and for as long as a response is being sent.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Bridge accepts a receive byte this cycle |
| tx_valid | output | 1 | Response byte present |
| tx_data | output | 8 | Response byte (count byte first) |
| tx_ready | input | 1 | Host takes the response byte |
| err_pulse | output | 1 | One-cycle flag for a rejected frame |
| pec_flag | output | 1 | Bit 7 of the last command byte |

## Verification
The bench builds the bridge with `IDX_W` = 4, so the array has 16 entries. With that size, a full 16-byte burst covers the whole array in one read, and every write length can be swept across every array index. Addresses with bit 16 set, and bases just below 2^17, are mapped onto the same small array. This exercises aliasing and the 17-bit wrap without a large memory. Each rejected frame is followed by a full-array read to show that nothing changed.

// File: rtl/smbrg_pkg.sv
// Shared constants and types for the block register bridge.
package smbrg_pkg;
    localparam int ADDR_W = 17;               // register address width
    localparam int WR_MAX = 4;                // longest write burst
    localparam int RD_MAX = 16;               // longest read burst
    localparam int WI_W   = $clog2(WR_MAX);   // write byte index width
    localparam int RL_W   = $clog2(RD_MAX) + 1;

    localparam logic [6:0] OP_WRITE   = 7'h0F;
    localparam logic [6:0] OP_RD_ARM  = 7'h0A;
    localparam logic [6:0] OP_RD_DATA = 7'h09;

    typedef enum logic [1:0] {TX_IDLE, TX_COUNT, TX_DATA} tx_state_e;
endpackage

// File: rtl/smbrg_frame_decoder.sv
// Frame decoder: captures the bytes of one frame, then in the cycle after
// the last byte judges the frame and issues a write commit, a fetch request
// or an error. Assumes frames are delimited only by the last-byte marker.
module smbrg_frame_decoder
    import smbrg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc,
    input  logic [7:0]              rx_data,
    input  logic                    rx_last,
    output logic                    done,
    output logic                    wr_commit,
    output logic [ADDR_W-1:0]       wr_base,
    output logic [WI_W:0]           wr_len,
    output logic [WR_MAX*8-1:0]     wr_bytes,
    output logic                    rd_go,
    output logic [RL_W-1:0]         rd_len,
    output logic [ADDR_W-1:0]       rd_base,
    output logic                    err,
    output logic                    pec_flag
);
    logic [3:0] nb_q, flen_q;
    logic [7:0] cmd_q, cnt_q, cfg_q, ahi_q, alo_q;
    logic [7:0] dat_q [WR_MAX];
    logic       done_q, arm_q;
    logic [ADDR_W-1:0] arm_base_q;
    logic [RL_W-1:0]   arm_len_q;
    logic [3:0] didx;
    logic [6:0] op;
    logic [3:0] m1;
    logic       wr_ok, arm_ok, fetch_ok;

    assign didx = nb_q - 4'd5;

    // Byte capture and frame length tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nb_q <= '0; flen_q <= '0; done_q <= 1'b0; pec_flag <= 1'b0;
            cmd_q <= '0; cnt_q <= '0; cfg_q <= '0; ahi_q <= '0; alo_q <= '0;
            for (int i = 0; i < WR_MAX; i++) dat_q[i] <= '0;
        end else begin
            done_q <= acc && rx_last;
            if (acc) begin
                case (nb_q)
                    4'd0: begin cmd_q <= rx_data; pec_flag <= rx_data[7]; end
                    4'd1: cnt_q <= rx_data;
                    4'd2: cfg_q <= rx_data;
                    4'd3: ahi_q <= rx_data;
                    4'd4: alo_q <= rx_data;
                    default: if (didx < 4'(WR_MAX)) dat_q[didx[WI_W-1:0]] <= rx_data;
                endcase
                if (rx_last) begin
                    nb_q   <= '0;
                    flen_q <= (nb_q == 4'hF) ? 4'hF : nb_q + 4'd1;
                end else if (nb_q != 4'hF) begin
                    nb_q <= nb_q + 4'd1;
                end
            end
        end
    end

    // Frame judgement on the registered fields.
    always_comb begin
        op       = cmd_q[6:0];
        m1       = cfg_q[4:1];
        wr_ok    = (op == OP_WRITE) && cfg_q[6] && (m1 < 4'(WR_MAX)) &&
                   (cnt_q == {4'd0, m1} + 8'd4) &&
                   ({4'd0, flen_q} == cnt_q + 8'd2 + {7'd0, cmd_q[7]});
        arm_ok   = (op == OP_RD_ARM) && !cfg_q[6] && (cnt_q == 8'd3) &&
                   (flen_q == 4'd5 + {3'd0, cmd_q[7]});
        fetch_ok = (op == OP_RD_DATA) && (flen_q == 4'd1);
    end

    assign done      = done_q;
    assign wr_commit = done_q && wr_ok;
    assign wr_base   = {cfg_q[0], ahi_q, alo_q};
    assign wr_len    = m1[WI_W:0] + 1'b1;
    assign rd_go     = done_q && fetch_ok;
    assign rd_len    = arm_q ? arm_len_q : '0;
    assign rd_base   = arm_base_q;
    assign err       = done_q && !(wr_ok || arm_ok || (fetch_ok && arm_q));

    generate
        for (genvar k = 0; k < WR_MAX; k++) begin : g_pack
            assign wr_bytes[k*8 +: 8] = dat_q[k];
        end
    endgenerate

    // Armed-read bookkeeping: set by an arming frame, consumed by a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0; arm_base_q <= '0; arm_len_q <= '0;
        end else if (done_q) begin
            if (op == OP_RD_ARM) begin
                arm_q      <= arm_ok;
                arm_base_q <= {cfg_q[0], ahi_q, alo_q};
                arm_len_q  <= RL_W'(m1) + 1'b1;
            end else if (fetch_ok) begin
                arm_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smbrg_reg_array.sv
// Local register array of 2**IDX_W bytes. Writes up to WR_MAX consecutive
// bytes in one cycle; one combinational read port. Address bits above
// IDX_W alias. Assumes IDX_W >= WI_W so burst bytes never collide.
module smbrg_reg_array
    import smbrg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   wr_base,
    input  logic [WI_W:0]       wr_len,
    input  logic [WR_MAX*8-1:0] wr_bytes,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [7:0]          rd_byte
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] widx [WR_MAX];

    generate
        for (genvar k = 0; k < WR_MAX; k++) begin : g_idx
            logic [ADDR_W-1:0] a_k;
            assign a_k     = wr_base + ADDR_W'(k);
            assign widx[k] = a_k[IDX_W-1:0];
        end
    endgenerate

    // Clear on reset; store the leading wr_len bytes of a committed burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int k = 0; k < WR_MAX; k++)
                if (k < int'(wr_len)) mem[widx[k]] <= wr_bytes[k*8 +: 8];
        end
    end

    assign rd_byte = mem[rd_addr[IDX_W-1:0]];
endmodule

// File: rtl/smbrg_resp_tx.sv
// Response sender: on a fetch request emits a count byte, then that many
// array bytes from consecutive addresses, each held until tx_ready.
module smbrg_resp_tx
    import smbrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [RL_W-1:0]   go_len,
    input  logic [ADDR_W-1:0] go_base,
    input  logic              tx_ready,
    input  logic [7:0]        rd_byte,
    output logic              busy,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic [ADDR_W-1:0] rd_addr
);
    tx_state_e         st_q;
    logic [RL_W-1:0]   len_q, rem_q;
    logic [ADDR_W-1:0] addr_q;

    // Sequencer for the count byte and the data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TX_IDLE; len_q <= '0; rem_q <= '0; addr_q <= '0;
        end else begin
            case (st_q)
                TX_IDLE: if (go) begin
                    st_q <= TX_COUNT; len_q <= go_len; rem_q <= go_len; addr_q <= go_base;
                end
                TX_COUNT: if (tx_ready) st_q <= (len_q == '0) ? TX_IDLE : TX_DATA;
                TX_DATA: if (tx_ready) begin
                    addr_q <= addr_q + 1'b1;
                    rem_q  <= rem_q - 1'b1;
                    if (rem_q == RL_W'(1)) st_q <= TX_IDLE;
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != TX_IDLE);
    assign tx_valid = busy;
    assign tx_data  = (st_q == TX_COUNT) ? 8'(len_q) : rd_byte;
    assign rd_addr  = addr_q;
endmodule

// File: rtl/smb_reg_bridge.sv
// Top of the block register bridge: receive stream into the frame decoder,
// decoder into the register array and the response sender.
module smb_reg_bridge
    import smbrg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_last,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       err_pulse,
    output logic       pec_flag
);
    logic                acc, done, busy, wr_commit, rd_go;
    logic [ADDR_W-1:0]   wr_base, rd_base, rd_addr;
    logic [WI_W:0]       wr_len;
    logic [WR_MAX*8-1:0] wr_bytes;
    logic [RL_W-1:0]     rd_len;
    logic [7:0]          rd_byte;

    assign rx_ready = !busy && !done;
    assign acc      = rx_valid && rx_ready;

    smbrg_frame_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .acc(acc), .rx_data(rx_data), .rx_last(rx_last),
        .done(done), .wr_commit(wr_commit), .wr_base(wr_base), .wr_len(wr_len),
        .wr_bytes(wr_bytes), .rd_go(rd_go), .rd_len(rd_len), .rd_base(rd_base),
        .err(err_pulse), .pec_flag(pec_flag)
    );

    smbrg_reg_array #(.IDX_W(IDX_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(wr_commit), .wr_base(wr_base), .wr_len(wr_len),
        .wr_bytes(wr_bytes), .rd_addr(rd_addr), .rd_byte(rd_byte)
    );

    smbrg_resp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .go(rd_go), .go_len(rd_len), .go_base(rd_base),
        .tx_ready(tx_ready), .rd_byte(rd_byte), .busy(busy), .tx_valid(tx_valid),
        .tx_data(tx_data), .rd_addr(rd_addr)
    );
endmodule

// File: rtl/smb_reg_bridge_chk.sv
// Protocol checker for the bridge ports, bound to every instance.
module smb_reg_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_last,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready,
    input logic       err_pulse,
    input logic       pec_flag
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !err_pulse && rx_ready));

    p_rx_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    p_err_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(rx_valid && rx_ready && rx_last));

    p_gap_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_last) |=> !rx_ready);

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind smb_reg_bridge smb_reg_bridge_chk u_chk (.*);

// File: tb/smb_reg_bridge_tb.sv
module smb_reg_bridge_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_last = 1'b0, tx_ready = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_ready, tx_valid, err_pulse, pec_flag;
    logic [7:0] tx_data;

    int total = 0, fails = 0;
    logic [7:0] mdl [16];
    logic [7:0] fb [16];
    int fn;
    logic [7:0] wb [4];
    logic [7:0] rbuf [16];
    int rcnt;
    logic last_err, last_rdy, last_err2;

    always #2.5 clk = ~clk;

    smb_reg_bridge #(.IDX_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .err_pulse(err_pulse),
        .pec_flag(pec_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Send fb[0..fn-1]; return at the second negedge after the last byte.
    task automatic send_frame();
        for (int i = 0; i < fn; i++) begin
            rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == fn - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        last_err = err_pulse; last_rdy = rx_ready;
        @(negedge clk);
        last_err2 = err_pulse;
    endtask

    task automatic collect();
        int g;
        tx_ready = 1'b1;
        g = 0;
        while (!tx_valid && g < 20) begin @(negedge clk); g++; end
        rcnt = tx_valid ? int'(tx_data) : 255;
        @(negedge clk);
        for (int i = 0; i < rcnt && i < 16; i++) begin
            g = 0;
            while (!tx_valid && g < 20) begin @(negedge clk); g++; end
            rbuf[i] = tx_data;
            @(negedge clk);
        end
        tx_ready = 1'b0;
    endtask

    task automatic wr(input logic [16:0] a, input int n, input logic [7:0] cmd, input bit pec_byte);
        fb[0] = cmd; fb[1] = 8'(3 + n);
        fb[2] = 8'h40 | 8'((n - 1) << 1) | {7'd0, a[16]};
        fb[3] = a[15:8]; fb[4] = a[7:0];
        for (int k = 0; k < n; k++) fb[5 + k] = wb[k];
        fn = 5 + n;
        if (pec_byte) begin fb[fn] = 8'h5C; fn++; end
        send_frame();
    endtask

    task automatic mdl_wr(input logic [16:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            logic [16:0] ak;
            ak = a + 17'(k);
            mdl[ak[3:0]] = wb[k];
        end
    endtask

    task automatic arm(input logic [16:0] a, input int n);
        fb[0] = 8'h0A; fb[1] = 8'd3;
        fb[2] = 8'((n - 1) << 1) | {7'd0, a[16]};
        fb[3] = a[15:8]; fb[4] = a[7:0]; fn = 5;
        send_frame();
    endtask

    task automatic fetch();
        fb[0] = 8'h09; fn = 1;
        send_frame();
        collect();
    endtask

    task automatic read_chk(input logic [16:0] a, input int n, input string tag);
        arm(a, n);
        fetch();
        chk({tag, " count"}, rcnt, n);
        for (int k = 0; k < n; k++) begin
            logic [16:0] ak;
            ak = a + 17'(k);
            chk({tag, " byte"}, int'(rbuf[k]), int'(mdl[ak[3:0]]));
        end
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rx_ready", rx_ready, 1);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 err", err_pulse, 0);
        chk("R1 pec_flag", pec_flag, 0);
        read_chk(17'h0, 16, "R1 cleared array");

        // R2: sweep every length over every array index, alternating bit 16
        for (int n = 1; n <= 4; n++) begin
            for (int a = 0; a < 16; a++) begin
                logic [16:0] ad;
                ad = {n[0], 16'((a * 32'h123) & 32'hFFFF)};
                for (int k = 0; k < 4; k++) wb[k] = 8'((n * 16 + a * 7 + k) ^ 8'hA5);
                wr(ad, n, 8'h0F, 1'b0);
                chk("R2 write accepted", last_err, 0);
                mdl_wr(ad, n);
            end
        end
        // R3: every read length from varied bases
        for (int n = 1; n <= 16; n++)
            read_chk({n[0], 16'(n * 5)}, n, "R3 burst read");

        // R2: wrap at the top of the 17-bit space
        wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33;
        wr(17'h1FFFF, 3, 8'h0F, 1'b0);
        chk("R2 wrap write", last_err, 0);
        mdl_wr(17'h1FFFF, 3);
        read_chk(17'h1FFFE, 4, "R2 wrap readback");

        // R4: fetch without an armed read, and a second fetch after use
        fetch();
        chk("R4 err unarmed", last_err, 1);
        chk("R4 count unarmed", rcnt, 0);
        arm(17'h3, 2);
        fetch();
        chk("R4 armed count", rcnt, 2);
        fetch();
        chk("R4 consumed err", last_err, 1);
        chk("R4 consumed count", rcnt, 0);

        // R5: malformed writes leave the array unchanged
        for (int k = 0; k < 4; k++) wb[k] = 8'hEE;
        wr(17'h2, 2, 8'h0F, 1'b0); // reference good frame shape, then mutate
        mdl_wr(17'h2, 2);
        fb[1] = 8'd6; fn = 7; send_frame();                    // count too large
        chk("R5 bad count", last_err, 1);
        fb[1] = 8'd5; fn = 6; send_frame();                    // short payload
        chk("R5 short payload", last_err, 1);
        fb[1] = 8'd5; fb[7] = 8'h77; fn = 8; send_frame();     // extra byte
        chk("R5 long payload", last_err, 1);
        fb[2] = 8'h02; fn = 7; fb[5] = 8'h99; fb[6] = 8'h99; send_frame(); // type bit 0
        chk("R5 type bit", last_err, 1);
        fb[0] = 8'h0F; fb[1] = 8'd8; fb[2] = 8'h48; fb[3] = 8'h0; fb[4] = 8'h0;
        for (int k = 0; k < 5; k++) fb[5 + k] = 8'h99;
        fn = 10; send_frame();                                 // five data bytes
        chk("R5 burst five", last_err, 1);
        read_chk(17'h0, 16, "R5 array unchanged");

        // R6: malformed arming frames, and a bad arm drops a good one
        arm(17'h0, 4);
        fb[1] = 8'd4; fb[5] = 8'h0; fn = 6; send_frame();
        chk("R6 bad count", last_err, 1);
        fetch();
        chk("R6 dropped arm", rcnt, 0);
        fb[0] = 8'h0A; fb[1] = 8'd3; fb[2] = 8'h46; fb[3] = 8'h0; fb[4] = 8'h0; fn = 5;
        send_frame();
        chk("R6 type bit", last_err, 1);
        fetch();
        chk("R6 no arm after type bit", rcnt, 0);

        // R7: unknown command and long fetch leave arm and array alone
        arm(17'h4, 3);
        fb[0] = 8'h0B; fb[1] = 8'd1; fn = 2; send_frame();
        chk("R7 unknown cmd", last_err, 1);
        fb[0] = 8'h09; fb[1] = 8'h00; fn = 2; send_frame();
        chk("R7 long fetch", last_err, 1);
        fetch();
        chk("R7 arm kept count", rcnt, 3);
        chk("R7 arm kept byte", int'(rbuf[0]), int'(mdl[4]));
        read_chk(17'h0, 16, "R7 array unchanged");

        // R8: checksum bit set adds one ignored trailing byte
        wb[0] = 8'h5A;
        wr(17'h9, 1, 8'h8F, 1'b1);
        chk("R8 pec write ok", last_err, 0);
        chk("R8 pec_flag set", pec_flag, 1);
        mdl_wr(17'h9, 1);
        wb[0] = 8'hC3;
        wr(17'h9, 1, 8'h8F, 1'b0);
        chk("R8 missing pec byte", last_err, 1);
        read_chk(17'h8, 2, "R8 readback");
        chk("R8 pec_flag clear", pec_flag, 0);

        // R9: rx_ready gap after the last byte and single-cycle error
        fb[0] = 8'h0B; fn = 1; send_frame();
        chk("R9 err present", last_err, 1);
        chk("R9 rx_ready gap", last_rdy, 0);
        chk("R9 err one cycle", last_err2, 0);

        // R10: response held while the host stalls
        arm(17'h8, 2);
        fb[0] = 8'h09; fn = 1; send_frame();
        begin
            logic [7:0] d0;
            d0 = tx_data;
            chk("R10 valid", tx_valid, 1);
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                chk("R10 held valid", tx_valid, 1);
                chk("R10 held data", int'(tx_data), int'(d0));
                chk("R9 rx blocked", rx_ready, 0);
            end
        end
        collect();
        chk("R10 count after stall", rcnt, 2);
        chk("R10 byte after stall", int'(rbuf[1]), int'(mdl[9]));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule